// File: doc/BRIEF.md
# Tile Visibility Resolver

This block finds, for each pixel of a square screen tile, the one opaque primitive that is nearest to the viewer. It then hands that answer to shading. Depth fragments for the tile come in one at a time, each carrying a pixel position, a depth and a primitive number. Each fragment is tested against a depth store held inside the block. A fragment that lands nearer than anything seen so far at its pixel overwrites the stored depth at once and claims the pixel in a tag store. Fragments that fail are dropped.

When the upstream raster stage pulses end-of-tile, the block stops accepting fragments and scans the tag store. It emits one shading request for every pixel that ended up covered, naming the winning primitive. Each pixel is therefore shaded no more than once. Because the winner is decided before any shading starts, the result for opaque geometry does not depend on the order in which primitives were submitted. After the scan, the tile state returns to empty, ready for the next tile.

Only positions and depths pass through this stage. Attribute fetch and shading happen downstream, once the requests have been issued.

Top module: `tile_hsr`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `shd_valid` is 0.
- R2: An empty pixel behaves as if it stores depth 16'hFFFF, and the test is strictly less-than. A fragment at depth 16'hFFFF therefore never covers a pixel.
- R3: A fragment whose depth is strictly less than the stored depth of its pixel replaces that depth and tag at once, so the very next fragment is tested against it. A fragment that fails is discarded.
- R4: A fragment whose depth equals the stored depth does not replace the tag, so the earlier primitive keeps the pixel.
- R5: A cycle with `in_ready`=1 and `tile_end`=1 starts resolve. From the next cycle, `in_ready` stays 0 until resolve ends, and `shd_valid` is never 1 while `in_ready` is 1.
- R6: Resolve visits the pixels in row-major order at address y*16+x, with x varying fastest. It emits exactly one request per covered pixel, giving (`shd_x`, `shd_y`, `shd_prim`), where `shd_prim` is the frontmost primitive. Uncovered pixels are skipped and emit nothing.
- R7: While `shd_valid`=1 and `shd_ready`=0, the request holds unchanged on the next cycle.
- R8: When resolve ends, every pixel returns to empty, so the next tile starts with no coverage left over.
- R9: For opaque fragments with distinct depths per pixel, the emitted winners are the same for any submission order.
- R10: A fragment accepted in the same cycle as `tile_end` belongs to the tile being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Fragment present |
| in_ready | output | 1 | Block accepts fragments and end-of-tile |
| in_x | input | 4 | Fragment column in tile |
| in_y | input | 4 | Fragment row in tile |
| in_depth | input | 16 | Fragment depth, smaller is nearer |
| in_prim | input | 12 | Primitive number of the fragment |
| tile_end | input | 1 | Strobe closing the current tile |
| shd_valid | output | 1 | Shading request present |
| shd_ready | input | 1 | Shading stage accepts the request |
| shd_x | output | 4 | Pixel column of the request |
| shd_y | output | 4 | Pixel row of the request |
| shd_prim | output | 12 | Visible primitive at that pixel |

## Verification
The bench drives complete tiles of arithmetically generated fragments over all 256 pixels and compares every request against a bench-side nearest-depth model.

- **Skipped or doubled pixels.** A block that skipped uncovered pixels wrongly, or emitted them, would break the request count. A wrong scan order would break the position sequence.
- **Depth ties and the empty-pixel value.** A less-or-equal test would give a tied pixel to the later primitive. A block that treated empty pixels as writable at maximum depth would emit a pixel covered only by a far-plane fragment.
- **Order and stalls.** Replaying one tile in reverse order exposes any dependence on submission order. A shading-side stall pattern catches requests that move while stalled.
- **Tile boundaries.** An empty tile following a full one exposes tag state that was not cleared. A fragment arriving together with the end strobe exposes a lost last fragment.

// File: rtl/tile_hsr.sv
module tile_hsr #(
  parameter int XW = 4,
  parameter int YW = 4,
  parameter int DW = 16,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [XW-1:0] in_x,
  input  logic [YW-1:0] in_y,
  input  logic [DW-1:0] in_depth,
  input  logic [TW-1:0] in_prim,
  input  logic          tile_end,
  output logic          shd_valid,
  input  logic          shd_ready,
  output logic [XW-1:0] shd_x,
  output logic [YW-1:0] shd_y,
  output logic [TW-1:0] shd_prim
);
  localparam int AW   = XW + YW;
  localparam int NPIX = 1 << AW;

  logic [DW-1:0]   zbuf [NPIX];
  logic [TW-1:0]   tbuf [NPIX];
  logic [NPIX-1:0] tvalid;
  logic            resolving;
  logic [AW-1:0]   scan;

  wire [AW-1:0] waddr = {in_y, in_x};
  wire [DW-1:0] zcur  = tvalid[waddr] ? zbuf[waddr] : {DW{1'b1}};
  wire          hit   = in_valid && !resolving && (in_depth < zcur);
  wire          step  = resolving && (!tvalid[scan] || shd_ready);

  assign in_ready  = !resolving;
  assign shd_valid = resolving && tvalid[scan];
  assign shd_x     = scan[XW-1:0];
  assign shd_y     = scan[AW-1:XW];
  assign shd_prim  = tbuf[scan];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resolving <= 1'b0;
      scan      <= '0;
      tvalid    <= '0;
    end else begin
      if (hit) tvalid[waddr] <= 1'b1;
      if (!resolving && tile_end) resolving <= 1'b1;
      if (step) begin
        scan <= scan + 1'b1;
        if (&scan) begin
          resolving <= 1'b0;
          tvalid    <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hit) begin
      zbuf[waddr] <= in_depth;
      tbuf[waddr] <= in_prim;
    end
  end
endmodule

// File: rtl/tile_hsr_chk.sv
module tile_hsr_chk #(
  parameter int XW = 4,
  parameter int YW = 4,
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          tile_end,
  input logic          shd_valid,
  input logic          shd_ready,
  input logic [XW-1:0] shd_x,
  input logic [YW-1:0] shd_y,
  input logic [TW-1:0] shd_prim
);
  logic [XW+YW-1:0] last;
  logic             seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      last <= '0;
    end else if (in_ready) begin
      seen <= 1'b0;
    end else if (shd_valid && shd_ready) begin
      seen <= 1'b1;
      last <= {shd_y, shd_x};
    end
  end

  // R5
  no_shade_in_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(shd_valid && in_ready));

  // R5
  enter_resolve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && tile_end) |=> !in_ready);

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_valid && !shd_ready) |=>
      (shd_valid && $stable(shd_x) && $stable(shd_y) && $stable(shd_prim)));

  // R6
  row_major_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shd_valid && seen) |-> ({shd_y, shd_x} > last));
endmodule

bind tile_hsr tile_hsr_chk #(.XW(XW), .YW(YW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .tile_end(tile_end),
  .shd_valid(shd_valid), .shd_ready(shd_ready), .shd_x(shd_x),
  .shd_y(shd_y), .shd_prim(shd_prim)
);

// File: tb/tile_hsr_tb.sv
module tile_hsr_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, in_valid, in_ready, tile_end, shd_valid, shd_ready;
  logic [3:0]  in_x, in_y, shd_x, shd_y;
  logic [15:0] in_depth;
  logic [11:0] in_prim, shd_prim;

  tile_hsr u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_depth(in_depth), .in_prim(in_prim),
    .tile_end(tile_end), .shd_valid(shd_valid), .shd_ready(shd_ready),
    .shd_x(shd_x), .shd_y(shd_y), .shd_prim(shd_prim)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int mz [256];
  int mt [256];
  bit mv [256];

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(int x, int y, int d, int p);
    int a = y * 16 + x;
    int cur = mv[a] ? mz[a] : 65535;
    if (d < cur) begin mv[a] = 1; mz[a] = d; mt[a] = p; end
  endtask

  task automatic send(int x, int y, int d, int p, bit last);
    @(negedge clk);
    in_valid = 1; in_x = 4'(x); in_y = 4'(y); in_depth = 16'(d);
    in_prim = 12'(p); tile_end = last;
    @(posedge clk);
    model(x, y, d, p);
  endtask

  task automatic close_tile(bit with_frag, string req);
    if (!with_frag) begin
      @(negedge clk);
      in_valid = 0; tile_end = 1;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; tile_end = 0;
    chk(in_ready == 0, req, in_ready, 0);
  endtask

  task automatic collect(string req);
    int ei = 0, emitted = 0, expn = 0, k = 0;
    bit stalled = 0;
    int sx = 0, sy = 0, sp = 0;
    for (int i = 0; i < 256; i++) if (mv[i]) expn++;
    while (!in_ready) begin
      shd_ready = (k % 3) != 2;
      #1;
      if (stalled)
        chk(shd_valid && shd_x == sx && shd_y == sy && shd_prim == sp,
            "R7", shd_prim, sp);
      stalled = 0;
      if (shd_valid) begin
        while (ei < 256 && !mv[ei]) ei++;
        chk(ei < 256 && {shd_y, shd_x} == ei, req, {shd_y, shd_x}, ei);
        if (ei < 256) chk(shd_prim == mt[ei], req, shd_prim, mt[ei]);
        if (shd_ready) begin ei++; emitted++; end
        else begin stalled = 1; sx = shd_x; sy = shd_y; sp = shd_prim; end
      end
      @(negedge clk);
      k++;
    end
    shd_ready = 0;
    chk(emitted == expn, req, emitted, expn);
    for (int i = 0; i < 256; i++) mv[i] = 0;
  endtask

  function automatic int dgen(int x, int y, int p);
    return ((x * 7 + y * 13 + p * 29) % 61) * 100 + p;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mv[i] = 0;
    rst_n = 0; in_valid = 0; tile_end = 0; shd_ready = 0;
    in_x = 0; in_y = 0; in_depth = 0; in_prim = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(in_ready == 1, "R1", in_ready, 1);
    chk(shd_valid == 0, "R1", shd_valid, 0);

    // R2 R3 R6 R7: four overlapping layers, some pixels never covered
    for (int p = 0; p < 4; p++)
      for (int a = 0; a < 256; a++)
        if (((a % 16) + (a / 16)) % 5 != 0)
          send(a % 16, a / 16, dgen(a % 16, a / 16, p), p + 1, 0);
    send(0, 0, 65535, 99, 0);
    close_tile(0, "R5");
    collect("R6");

    // R9: same fragments in reverse order
    for (int p = 3; p >= 0; p--)
      for (int a = 255; a >= 0; a--)
        if (((a % 16) + (a / 16)) % 5 != 0)
          send(a % 16, a / 16, dgen(a % 16, a / 16, p), p + 1, 0);
    close_tile(0, "R5");
    collect("R9");

    // R4 ties, R3 nearer later fragment, R2 far plane
    for (int x = 0; x < 8; x++) begin
      send(x, 3, 500, 7, 0);
      send(x, 3, 500, 8, 0);
    end
    for (int x = 0; x < 16; x++) begin
      send(x, 15, 300, 20, 0);
      send(x, 15, 200, 21, 0);
      send(x, 15, 250, 22, 0);
    end
    send(9, 9, 65535, 40, 0);
    close_tile(0, "R5");
    collect("R4");

    // R8: empty tile after covered ones
    close_tile(0, "R5");
    collect("R8");

    // R10: fragment together with end strobe
    send(2, 2, 40, 30, 0);
    send(5, 5, 10, 33, 1);
    close_tile(1, "R10");
    collect("R10");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule